// File: doc/BRIEF.md
# Two-Tier Rate Queue Cell Shaper

This block chooses, once per cell slot on a shared ATM link, which virtual circuit may emit its next cell. Every VC is bound to one of eight rate queues. Each queue owns a programmable interval timer, counted in cell-slot ticks, that fixes its peak rate. Queues 0 to 3 form a high-priority group and queues 4 to 7 a low-priority group. A low queue gets a slot only when no high queue can use it, so a low queue may starve, and a flag reports that case.

Inside a queue the ready VCs are served in round-robin order. A per-VC divider lets a VC use the full peak rate of its queue, half of it or a quarter of it. A per-VC token bucket caps the long-term rate: tokens arrive at the peak rate divided by n, with n from 1 to 8, and each sent cell uses one. While the bucket holds tokens the VC bursts at its peak rate. Once the bucket is empty it is held to the token arrival rate. When no VC can use a slot, the block reports an idle slot so that an idle cell can be inserted further down the path.

The block has two configuration ports. One binds a VC to its queue and sets its divider, its rate ratio and its bucket depth. The other sets the interval of a queue. Each VC has one "ready" input. The slot tick is an input, and the decision comes out one clock after the tick.

Top module: `rate_queue_shaper`

## Requirements
- R1: While reset is held, and after it until the first slot tick, no send, no idle slot and no starvation flag are reported. After reset every queue interval is 1, every VC is bound to queue 0 with an empty bucket of depth 0, and every round-robin pointer sits at the last VC, so the first candidate is VC 0.
- R2: A clock with `slot_tick` high yields, on the next clock, exactly one of `send_vld` or `send_idle` for one cycle. A clock without a tick yields neither.
- R3: A queue with interval I is due on every I-th tick after its interval was written or after reset. An interval of 0 behaves as 1.
- R4: When several queues are due and have candidates in the same slot, the lowest queue index wins. Queues 0–3 therefore always take precedence over queues 4–7.
- R5: On each tick, `q_starve[q]` is set when queue q was due and had an eligible VC but did not win the slot, and cleared otherwise. It holds its value between ticks.
- R6: Among the eligible VCs of one queue, the first VC after the one the queue last sent is chosen, in ascending VC index order with wrap-around.
- R7: The 2-bit divider field selects the usable share of the queue's due slots. Code 0 uses every due slot. Code 1 uses the slots where the VC's count of due slots since provisioning is even. Codes 2 and 3 use the slots where that count is a multiple of 4.
- R8: A VC is eligible only if it is ready, its bucket is non-empty, its divider allows the slot and its queue is due. Each cell sent removes one token.
- R9: The 3-bit rate field holds n−1. One token is generated on every n-th due slot of the VC's queue, whether or not the VC sends. A token that would take the bucket above its depth is discarded.
- R10: A slot with no eligible VC in any due queue is reported as `send_idle`.
- R11: A provisioning write rebinds a VC to its new queue and reloads its divider, ratio and depth. It fills the bucket to the depth and clears the VC's divider count and token count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| vc_cfg_we | input | 1 | VC provisioning write strobe |
| vc_cfg_id | input | 7 | VC being provisioned |
| vc_cfg_queue | input | 3 | Queue the VC is bound to |
| vc_cfg_div | input | 2 | Peak share: 0 full, 1 half, 2/3 quarter |
| vc_cfg_scr_m1 | input | 3 | Rate ratio n minus one |
| vc_cfg_depth | input | 4 | Token bucket depth |
| q_cfg_we | input | 1 | Queue interval write strobe |
| q_cfg_sel | input | 3 | Queue being written |
| q_cfg_ival | input | 12 | Queue interval in slot ticks |
| vc_ready | input | 128 | Per-VC packet-ready flags |
| slot_tick | input | 1 | One cell slot is available |
| send_vld | output | 1 | A VC sends in the slot just decided |
| send_vc | output | 7 | VC that sends |
| send_idle | output | 1 | No VC can use the slot |
| q_starve | output | 8 | Per-queue starvation flags |

## Verification
A bucket count that is off by one shows up at the ports within one burst. It appears as an extra cell or a missing cell, on the tick where the reference model expects the other outcome. A phase counter or interval counter that drifts moves a send to a different tick, or replaces it with an idle slot, within four due slots. A round-robin pointer that is not updated repeats a VC on the next due slot of its queue. The model is compared against every output on every clock, so each of these faults appears in the cycle right after the first wrong decision.

// File: rtl/rqs_pkg.sv
package rqs_pkg;
  localparam int NQ    = 8;
  localparam int NQ_HI = 4;
  localparam int QW    = $clog2(NQ);

  typedef enum logic [1:0] {
    DIV_FULL  = 2'd0,
    DIV_HALF  = 2'd1,
    DIV_QTR   = 2'd2,
    DIV_QTR_B = 2'd3
  } div_e;
endpackage

// File: rtl/rqs_qtimer.sv
module rqs_qtimer #(
  parameter int IVW = 12
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           tick,
  input  logic           we,
  input  logic [IVW-1:0] ival_in,
  output logic           expire
);
  logic [IVW-1:0] ival, cnt;
  logic [IVW:0]   nxt, eff;

  always_comb begin
    nxt    = {1'b0, cnt} + (IVW+1)'(1);
    eff    = (ival == '0) ? (IVW+1)'(1) : {1'b0, ival};
    expire = tick && (nxt >= eff);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ival <= IVW'(1);
      cnt  <= '0;
    end else if (we) begin
      ival <= ival_in;
      cnt  <= '0;
    end else if (tick) begin
      cnt <= expire ? '0 : nxt[IVW-1:0];
    end
  end
endmodule

// File: rtl/rqs_vc_slot.sv
module rqs_vc_slot
  import rqs_pkg::*;
#(
  parameter int DW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [QW-1:0] cfg_q,
  input  div_e          cfg_div,
  input  logic [2:0]    cfg_scr,
  input  logic [DW-1:0] cfg_depth,
  input  logic          ready,
  input  logic [NQ-1:0] q_exp,
  input  logic          grant,
  output logic [QW-1:0] q,
  output logic          ok
);
  div_e          div;
  logic [2:0]    scr, gc;
  logic [1:0]    ph;
  logic [DW-1:0] tok, depth;
  logic          my_exp, ph_ok, gen, full_hold;

  always_comb begin
    my_exp = q_exp[q];
    case (div)
      DIV_FULL: ph_ok = 1'b1;
      DIV_HALF: ph_ok = !ph[0];
      default:  ph_ok = (ph == 2'd0);
    endcase
    ok        = ready && (tok != '0) && ph_ok && my_exp;
    gen       = my_exp && (gc == scr);
    full_hold = (tok == depth) && !grant;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      q     <= '0;
      div   <= DIV_FULL;
      scr   <= '0;
      depth <= '0;
      tok   <= '0;
      ph    <= '0;
      gc    <= '0;
    end else if (we) begin
      q     <= cfg_q;
      div   <= cfg_div;
      scr   <= cfg_scr;
      depth <= cfg_depth;
      tok   <= cfg_depth;
      ph    <= '0;
      gc    <= '0;
    end else begin
      if (my_exp) begin
        ph <= ph + 2'd1;
        gc <= gen ? 3'd0 : gc + 3'd1;
      end
      tok <= tok - DW'(grant) + DW'(gen && !full_hold);
    end
  end
endmodule

// File: rtl/rqs_rr_pick.sv
module rqs_rr_pick #(
  parameter int N  = 128,
  parameter int IW = $clog2(N)
) (
  input  logic [N-1:0]  req,
  input  logic [IW-1:0] last,
  output logic          found,
  output logic [IW-1:0] idx
);
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = 0; i < N; i++) begin
      if (!found && req[(int'(last) + 1 + i) % N]) begin
        found = 1'b1;
        idx   = IW'((int'(last) + 1 + i) % N);
      end
    end
  end
endmodule

// File: rtl/rate_queue_shaper.sv
module rate_queue_shaper
  import rqs_pkg::*;
#(
  parameter int NVC = 128,
  parameter int IVW = 12,
  parameter int DW  = 4,
  localparam int VCW = $clog2(NVC)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            vc_cfg_we,
  input  logic [VCW-1:0]  vc_cfg_id,
  input  logic [2:0]      vc_cfg_queue,
  input  logic [1:0]      vc_cfg_div,
  input  logic [2:0]      vc_cfg_scr_m1,
  input  logic [DW-1:0]   vc_cfg_depth,
  input  logic            q_cfg_we,
  input  logic [2:0]      q_cfg_sel,
  input  logic [IVW-1:0]  q_cfg_ival,
  input  logic [NVC-1:0]  vc_ready,
  input  logic            slot_tick,
  output logic            send_vld,
  output logic [VCW-1:0]  send_vc,
  output logic            send_idle,
  output logic [NQ-1:0]   q_starve
);
  logic [NQ-1:0]  q_exp, fnd;
  logic [VCW-1:0] pidx   [NQ];
  logic [VCW-1:0] last_r [NQ];
  logic [NVC-1:0] req    [NQ];
  logic [QW-1:0]  vq     [NVC];
  logic [NVC-1:0] vok, grant;
  logic           win_any;
  logic [QW-1:0]  win_q, sent_q;
  logic [VCW-1:0] win_vc;

  for (genvar g = 0; g < NQ; g++) begin : g_q
    rqs_qtimer #(.IVW(IVW)) u_tmr (
      .clk(clk), .rst(rst), .tick(slot_tick),
      .we(q_cfg_we && (q_cfg_sel == QW'(g))),
      .ival_in(q_cfg_ival), .expire(q_exp[g])
    );
    rqs_rr_pick #(.N(NVC)) u_pick (
      .req(req[g]), .last(last_r[g]), .found(fnd[g]), .idx(pidx[g])
    );
  end

  for (genvar v = 0; v < NVC; v++) begin : g_vc
    rqs_vc_slot #(.DW(DW)) u_vc (
      .clk(clk), .rst(rst),
      .we(vc_cfg_we && (vc_cfg_id == VCW'(v))),
      .cfg_q(vc_cfg_queue), .cfg_div(div_e'(vc_cfg_div)),
      .cfg_scr(vc_cfg_scr_m1), .cfg_depth(vc_cfg_depth),
      .ready(vc_ready[v]), .q_exp(q_exp), .grant(grant[v]),
      .q(vq[v]), .ok(vok[v])
    );
  end

  always_comb begin
    for (int g = 0; g < NQ; g++)
      for (int v = 0; v < NVC; v++)
        req[g][v] = vok[v] && (vq[v] == QW'(g));
  end

  // Descending scan: the lowest-index queue with a candidate is assigned last.
  always_comb begin
    win_any = 1'b0;
    win_q   = '0;
    win_vc  = '0;
    for (int g = NQ - 1; g >= 0; g--) begin
      if (fnd[g]) begin
        win_any = 1'b1;
        win_q   = QW'(g);
        win_vc  = pidx[g];
      end
    end
    for (int v = 0; v < NVC; v++)
      grant[v] = win_any && (win_vc == VCW'(v));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      send_vld  <= 1'b0;
      send_idle <= 1'b0;
      send_vc   <= '0;
      sent_q    <= '0;
      q_starve  <= '0;
      for (int g = 0; g < NQ; g++) last_r[g] <= VCW'(NVC - 1);
    end else begin
      send_vld  <= slot_tick && win_any;
      send_idle <= slot_tick && !win_any;
      if (slot_tick) begin
        send_vc <= win_vc;
        sent_q  <= win_q;
        for (int g = 0; g < NQ; g++)
          q_starve[g] <= q_exp[g] && fnd[g] && !(win_any && (win_q == QW'(g)));
        if (win_any) last_r[win_q] <= win_vc;
      end
    end
  end
endmodule

// File: rtl/rqs_checker.sv
module rqs_checker
  import rqs_pkg::*;
(
  input logic          clk,
  input logic          rst,
  input logic          slot_tick,
  input logic          send_vld,
  input logic          send_idle,
  input logic [NQ-1:0] q_starve,
  input logic [QW-1:0] sent_q
);
  // R1
  a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (!send_vld && !send_idle && q_starve == '0));
  // R2
  a_r2_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(send_vld && send_idle));
  a_r2_tick_outcome: assert property (@(posedge clk) disable iff (rst)
    slot_tick |=> (send_vld || send_idle));
  a_r2_no_tick_quiet: assert property (@(posedge clk) disable iff (rst)
    !slot_tick |=> (!send_vld && !send_idle));
  // R5
  a_r5_starve_held: assert property (@(posedge clk) disable iff (rst)
    !slot_tick |=> $stable(q_starve));
  a_r5_winner_not_starved: assert property (@(posedge clk) disable iff (rst)
    send_vld |-> !q_starve[sent_q]);
  // R4
  a_r4_high_first: assert property (@(posedge clk) disable iff (rst)
    (send_vld && (int'(sent_q) >= NQ_HI)) |-> (q_starve[NQ_HI-1:0] == '0));
endmodule

bind rate_queue_shaper rqs_checker u_chk (
  .clk(clk), .rst(rst), .slot_tick(slot_tick), .send_vld(send_vld),
  .send_idle(send_idle), .q_starve(q_starve), .sent_q(sent_q)
);

// File: tb/sim_rate_queue_shaper.sv
module sim_rate_queue_shaper;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 128;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         vc_cfg_we = 1'b0;
  logic [6:0]   vc_cfg_id = '0;
  logic [2:0]   vc_cfg_queue = '0;
  logic [1:0]   vc_cfg_div = '0;
  logic [2:0]   vc_cfg_scr_m1 = '0;
  logic [3:0]   vc_cfg_depth = '0;
  logic         q_cfg_we = 1'b0;
  logic [2:0]   q_cfg_sel = '0;
  logic [11:0]  q_cfg_ival = '0;
  logic [NV-1:0] rdy = '0;
  logic         slot_tick = 1'b0;
  logic         send_vld, send_idle;
  logic [6:0]   send_vc;
  logic [7:0]   q_starve;

  rate_queue_shaper u0 (
    .clk(clk), .rst(rst), .vc_cfg_we(vc_cfg_we), .vc_cfg_id(vc_cfg_id),
    .vc_cfg_queue(vc_cfg_queue), .vc_cfg_div(vc_cfg_div),
    .vc_cfg_scr_m1(vc_cfg_scr_m1), .vc_cfg_depth(vc_cfg_depth),
    .q_cfg_we(q_cfg_we), .q_cfg_sel(q_cfg_sel), .q_cfg_ival(q_cfg_ival),
    .vc_ready(rdy), .slot_tick(slot_tick), .send_vld(send_vld),
    .send_vc(send_vc), .send_idle(send_idle), .q_starve(q_starve)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_run = 0, n_fail = 0, cyc = 0;
  string tag = "R1";

  // Behavioural reference model
  int m_q[NV], m_div[NV], m_scr[NV], m_dep[NV], m_tok[NV], m_ph[NV], m_gc[NV];
  int m_ival[8], m_cnt[8], m_last[8];
  bit e_vld, e_idle;
  int e_vc;
  bit [7:0] e_starve;

  function automatic bit div_ok(int v);
    if (m_div[v] == 0) return 1'b1;
    if (m_div[v] == 1) return (m_ph[v] % 2) == 0;
    return m_ph[v] == 0;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      for (int v = 0; v < NV; v++) begin
        m_q[v] = 0; m_div[v] = 0; m_scr[v] = 0; m_dep[v] = 0;
        m_tok[v] = 0; m_ph[v] = 0; m_gc[v] = 0;
      end
      for (int q = 0; q < 8; q++) begin
        m_ival[q] = 1; m_cnt[q] = 0; m_last[q] = NV - 1;
      end
      e_vld = 0; e_idle = 0; e_vc = 0; e_starve = '0;
    end else begin
      if (slot_tick) begin
        bit exp[8];
        int cand[8];
        int win;
        for (int q = 0; q < 8; q++) begin
          int eff;
          eff = (m_ival[q] == 0) ? 1 : m_ival[q];
          exp[q] = (m_cnt[q] + 1 >= eff);
          m_cnt[q] = exp[q] ? 0 : m_cnt[q] + 1;
          cand[q] = -1;
          for (int i = 0; i < NV; i++) begin
            int v;
            v = (m_last[q] + 1 + i) % NV;
            if (cand[q] < 0 && exp[q] && m_q[v] == q && rdy[v] && m_tok[v] > 0 && div_ok(v))
              cand[q] = v;
          end
        end
        win = -1;
        for (int q = 7; q >= 0; q--) if (cand[q] >= 0) win = q;
        for (int q = 0; q < 8; q++) e_starve[q] = exp[q] && cand[q] >= 0 && q != win;
        for (int v = 0; v < NV; v++) begin
          if (exp[m_q[v]]) begin
            bit gen;
            gen = (m_gc[v] == m_scr[v]);
            m_gc[v] = gen ? 0 : m_gc[v] + 1;
            m_ph[v] = (m_ph[v] + 1) % 4;
            m_tok[v] = m_tok[v] + (gen ? 1 : 0) - ((win >= 0 && cand[win] == v) ? 1 : 0);
            if (m_tok[v] > m_dep[v]) m_tok[v] = m_dep[v];
          end
        end
        e_vld = (win >= 0);
        e_idle = (win < 0);
        if (win >= 0) begin
          e_vc = cand[win];
          m_last[win] = cand[win];
        end
      end else begin
        e_vld = 0; e_idle = 0;
      end
      if (vc_cfg_we) begin
        m_q[vc_cfg_id] = vc_cfg_queue; m_div[vc_cfg_id] = vc_cfg_div;
        m_scr[vc_cfg_id] = vc_cfg_scr_m1; m_dep[vc_cfg_id] = vc_cfg_depth;
        m_tok[vc_cfg_id] = vc_cfg_depth; m_ph[vc_cfg_id] = 0; m_gc[vc_cfg_id] = 0;
      end
      if (q_cfg_we) begin
        m_ival[q_cfg_sel] = q_cfg_ival; m_cnt[q_cfg_sel] = 0;
      end
    end
  end

  task automatic chk(bit ok, string what, int act, int expv);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d (t=%0t)", tag, what, act, expv, $time);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    if (!rst) begin
      chk(send_vld == e_vld, "send_vld", send_vld, e_vld);
      chk(send_idle == e_idle, "send_idle", send_idle, e_idle);
      if (e_vld) chk(send_vc == 7'(e_vc), "send_vc", send_vc, e_vc);
      chk(q_starve == e_starve, "q_starve", q_starve, e_starve);
    end
    if (cyc > 150000) begin
      n_fail++;
      $display("FAIL R2 watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  task automatic cfg_vc(int v, int q, int dv, int scr_m1, int dep);
    @(negedge clk);
    slot_tick = 0;
    vc_cfg_we = 1; vc_cfg_id = 7'(v); vc_cfg_queue = 3'(q);
    vc_cfg_div = 2'(dv); vc_cfg_scr_m1 = 3'(scr_m1); vc_cfg_depth = 4'(dep);
    @(negedge clk);
    vc_cfg_we = 0;
  endtask

  task automatic cfg_q(int q, int iv);
    @(negedge clk);
    slot_tick = 0;
    q_cfg_we = 1; q_cfg_sel = 3'(q); q_cfg_ival = 12'(iv);
    @(negedge clk);
    q_cfg_we = 0;
  endtask

  task automatic ticks(int n, int every);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      slot_tick = (i % every) == 0;
    end
    @(negedge clk);
    slot_tick = 0;
  endtask

  initial begin
    tag = "R1";
    repeat (4) @(negedge clk);
    rst = 0;
    repeat (4) @(negedge clk);

    tag = "R10";
    ticks(4, 1);
    tag = "R2";
    ticks(9, 3);

    tag = "R3";
    cfg_q(0, 3);
    cfg_vc(0, 0, 0, 0, 15);
    rdy[0] = 1;
    ticks(13, 1);
    cfg_q(0, 0);
    ticks(4, 1);

    tag = "R6";
    cfg_q(0, 1);
    for (int v = 1; v < 4; v++) cfg_vc(v, 0, 0, 0, 15);
    rdy[3:1] = '1;
    ticks(12, 1);

    tag = "R4";
    rdy = '0;
    cfg_vc(10, 1, 0, 0, 15);
    cfg_vc(20, 4, 0, 0, 15);
    cfg_vc(21, 5, 0, 0, 15);
    rdy[10] = 1; rdy[20] = 1; rdy[21] = 1;
    ticks(8, 1);
    tag = "R5";
    rdy[10] = 0;
    ticks(6, 1);
    rdy[20] = 0;
    ticks(4, 1);

    tag = "R7";
    rdy = '0;
    cfg_vc(30, 2, 1, 0, 15);
    cfg_vc(31, 3, 2, 0, 15);
    cfg_vc(32, 6, 3, 0, 15);
    rdy[30] = 1; rdy[31] = 1; rdy[32] = 1;
    ticks(16, 1);

    tag = "R8";
    rdy = '0;
    cfg_vc(40, 7, 0, 2, 2);
    rdy[40] = 1;
    ticks(20, 1);
    tag = "R9";
    rdy[40] = 0;
    ticks(12, 1);
    rdy[40] = 1;
    ticks(12, 1);

    tag = "R11";
    cfg_vc(40, 1, 0, 0, 3);
    ticks(8, 1);
    cfg_q(1, 2);
    ticks(8, 1);

    tag = "R2";
    for (int q = 0; q < 8; q++) cfg_q(q, 1 + (q % 3));
    for (int v = 0; v < 48; v++) cfg_vc(v, v % 8, v % 4, v % 8, v % 16);
    for (int k = 0; k < 3000; k++) begin
      @(negedge clk);
      slot_tick = ($urandom % 4) != 0;
      if (($urandom % 8) == 0) rdy[$urandom % 48] ^= 1'b1;
    end
    @(negedge clk);
    slot_tick = 0;
    repeat (3) @(negedge clk);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule